// File: doc/BRIEF.md
# Three-Wire Polarity Symbol Decoder

This block sits behind a clock-recovery stage on a three-wire link where each wire carries one of three distinct levels in every unit interval. For each interval the recovery stage delivers three comparator signs, one per pairwise wire difference, together with a sample strobe. The decoder works out from those signs which of the six wire states the link is in. It then recovers a base-5 digit (0 to 4) from the step between the previous state and the current one. The levels themselves carry no information and are never looked at. Only the ordering of the wires matters.

The decoder is the exact inverse of a transmit-side rule: the new state index equals the old index plus the digit plus one, modulo six. So a loopback of any digit stream through that rule comes back unchanged. Sign patterns that no legal state can produce are flagged, and so is an interval that repeats the previous state. Neither case yields a digit.

Top module: `trio_symbol_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dig_vld_o`, `err_invalid_o` and `err_repeat_o` are all low.
- R2: `pol_i` bit 0 is the sign of A minus B, bit 1 the sign of B minus C, and bit 2 the sign of C minus A (1 means positive). The state index from `pol_i` = 001, 011, 010, 110, 100, 101 is 0, 1, 2, 3, 4, 5 respectively.
- R3: For a legal, non-repeated sample that follows an earlier legal sample, the decoder emits a digit. The digit equals ((current index minus previous index) mod 6) minus 1.
- R4: Every result (digit or flag) is a single-cycle pulse in the cycle after the strobed sample. When the strobe is low, `pol_i` is ignored and no result appears.
- R5: The first legal sample after reset only records the state. It produces no digit and no flag.
- R6: A strobed `pol_i` of 000 or 111 raises `err_invalid_o`, produces no digit and leaves the recorded state untouched.
- R7: A legal sample that equals the recorded state raises `err_repeat_o` and produces no digit.
- R8: At most one of `dig_vld_o`, `err_invalid_o`, `err_repeat_o` is high in any cycle.
- R9: Whenever `dig_vld_o` is high, `dig_o` lies in 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample strobe from clock recovery |
| pol_i | input | 3 | Comparator signs: {C>A, B>C, A>B} |
| dig_vld_o | output | 1 | Digit valid pulse |
| dig_o | output | 3 | Recovered base-5 digit |
| err_invalid_o | output | 1 | Sign pattern matches no wire state |
| err_repeat_o | output | 1 | Wire state did not change |

## Verification
The assertions assume only that `smp_vld_i` and `pol_i` are stable around the clock edge. They place no restriction on which patterns arrive, so illegal patterns and repeats are legitimate stimulus. The bench encodes digit streams into wire levels for A, B and C and derives the three signs from those levels, which keeps the stimulus at the comparator interface. It then deliberately mixes in gaps without a strobe, repeated states, all-equal sign patterns, and an illegal pattern as the very first sample after a mid-run reset.

// File: rtl/trio_dec_pkg.sv
`timescale 1ns/1ps
package trio_dec_pkg;
  localparam int NPAIR  = 3;
  localparam int NSTATE = 6;
  localparam int NDIGIT = NSTATE - 1;
  localparam int IDX_W  = $clog2(NSTATE);
  localparam int DIG_W  = $clog2(NDIGIT);

  typedef logic [NPAIR-1:0] pol_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [DIG_W-1:0] dig_t;

  // A valid ordering of three distinct levels never gives all-equal signs
  function automatic logic pol_legal(pol_t p);
    return !((p == '0) || (p == '1));
  endfunction

  // Sign pattern {C>A, B>C, A>B} to wire-state index
  function automatic idx_t pol_to_idx(pol_t p);
    case (p)
      3'b001:  return idx_t'(0);
      3'b011:  return idx_t'(1);
      3'b010:  return idx_t'(2);
      3'b110:  return idx_t'(3);
      3'b100:  return idx_t'(4);
      3'b101:  return idx_t'(5);
      default: return idx_t'(0);
    endcase
  endfunction

  // Forward distance around the state ring, minus one
  function automatic dig_t step_digit(idx_t prv, idx_t cur);
    int d;
    d = (int'(cur) - int'(prv) + NSTATE) % NSTATE;
    return dig_t'(d - 1);
  endfunction
endpackage

// File: rtl/trio_pol_classify.sv
`timescale 1ns/1ps
module trio_pol_classify
  import trio_dec_pkg::*;
(
  input  pol_t pol_i,
  output idx_t idx_o,
  output logic legal_o
);
  always_comb begin
    legal_o = pol_legal(pol_i);
    idx_o   = pol_to_idx(pol_i);
  end
endmodule

// File: rtl/trio_state_track.sv
`timescale 1ns/1ps
module trio_state_track
  import trio_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  idx_t cur_i,
  output idx_t prv_o,
  output logic primed_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_o    <= '0;
      primed_o <= 1'b0;
    end else if (upd_i) begin
      prv_o    <= cur_i;
      primed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/trio_step_decode.sv
`timescale 1ns/1ps
module trio_step_decode
  import trio_dec_pkg::*;
(
  input  idx_t prv_i,
  input  idx_t cur_i,
  output logic same_o,
  output dig_t dig_o
);
  always_comb begin
    same_o = (prv_i == cur_i);
    dig_o  = step_digit(prv_i, cur_i);
  end
endmodule

// File: rtl/trio_symbol_decoder.sv
`timescale 1ns/1ps
module trio_symbol_decoder
  import trio_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld_i,
  input  logic [2:0] pol_i,
  output logic       dig_vld_o,
  output logic [2:0] dig_o,
  output logic       err_invalid_o,
  output logic       err_repeat_o
);
  idx_t cur_idx;
  idx_t prv_idx;
  logic pat_legal;
  logic primed;
  logic same_state;
  dig_t step_dig;

  // Named events for inspection
  logic smp_legal;
  logic smp_illegal;
  logic smp_first;
  logic smp_repeat;
  logic smp_step;

  trio_pol_classify u_cls (
    .pol_i   (pol_i),
    .idx_o   (cur_idx),
    .legal_o (pat_legal)
  );

  trio_state_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (smp_legal),
    .cur_i    (cur_idx),
    .prv_o    (prv_idx),
    .primed_o (primed)
  );

  trio_step_decode u_dec (
    .prv_i  (prv_idx),
    .cur_i  (cur_idx),
    .same_o (same_state),
    .dig_o  (step_dig)
  );

  always_comb begin
    smp_legal   = smp_vld_i && pat_legal;
    smp_illegal = smp_vld_i && !pat_legal;
    smp_first   = smp_legal && !primed;
    smp_repeat  = smp_legal && primed && same_state;
    smp_step    = smp_legal && primed && !same_state;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_vld_o     <= 1'b0;
      dig_o         <= '0;
      err_invalid_o <= 1'b0;
      err_repeat_o  <= 1'b0;
    end else begin
      dig_vld_o     <= smp_step;
      err_invalid_o <= smp_illegal;
      err_repeat_o  <= smp_repeat;
      if (smp_step) dig_o <= step_dig;
    end
  end
endmodule

// File: rtl/trio_symbol_decoder_chk.sv
`timescale 1ns/1ps
module trio_symbol_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld_i,
  input logic [2:0] pol_i,
  input logic       dig_vld_o,
  input logic [2:0] dig_o,
  input logic       err_invalid_o,
  input logic       err_repeat_o
);
  logic in_legal;
  logic seen;

  assign in_legal = (pol_i != 3'b000) && (pol_i != 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (smp_vld_i && in_legal) seen <= 1'b1;
  end

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dig_vld_o, err_invalid_o, err_repeat_o}));

  // R9
  dig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dig_vld_o |-> (dig_o <= 3'd4));

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_vld_o || err_invalid_o || err_repeat_o) |-> $past(smp_vld_i));

  // R6
  invalid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !in_legal) |=> err_invalid_o);

  // R5
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && in_legal && !seen) |=> (!dig_vld_o && !err_repeat_o));
endmodule

bind trio_symbol_decoder trio_symbol_decoder_chk u_chk (.*);

// File: tb/trio_symbol_decoder_bench.sv
`timescale 1ns/1ps
module trio_symbol_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld_i = 1'b0;
  logic [2:0] pol_i = 3'b000;
  logic       dig_vld_o;
  logic [2:0] dig_o;
  logic       err_invalid_o;
  logic       err_repeat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int    m_prev;
  bit    m_primed;
  int    tx_state;
  bit    e_vld, e_inv, e_rep;
  int    e_dig;
  string e_tag;

  trio_symbol_decoder u_trio_symbol_decoder (.*);

  always #2.5 clk = ~clk;

  // Wire levels per state: 2 high, 1 mid, 0 low
  function automatic logic [2:0] pol_of(int k);
    int la[6] = '{2, 2, 1, 0, 0, 1};
    int lb[6] = '{0, 1, 2, 2, 1, 0};
    int lc[6] = '{1, 0, 0, 1, 2, 2};
    return {lc[k] > la[k], lb[k] > lc[k], la[k] > lb[k]};
  endfunction

  function automatic int idx_of(logic [2:0] p);
    for (int k = 0; k < 6; k++) if (pol_of(k) == p) return k;
    return -1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic compare();
    checks++;
    if (dig_vld_o !== e_vld || err_invalid_o !== e_inv || err_repeat_o !== e_rep ||
        (e_vld && dig_o !== 3'(e_dig))) begin
      fails++;
      $display("FAIL %s: vld/inv/rep/dig = %b%b%b/%0d expected %b%b%b/%0d",
               e_tag, dig_vld_o, err_invalid_o, err_repeat_o, dig_o,
               e_vld, e_inv, e_rep, e_dig);
    end
    checks++;
    if ((int'(dig_vld_o) + int'(err_invalid_o) + int'(err_repeat_o)) > 1 ||
        (dig_vld_o && dig_o > 3'd4)) begin
      fails++;
      $display("FAIL R8/R9: vld/inv/rep/dig = %b%b%b/%0d expected exclusive, digit<=4",
               dig_vld_o, err_invalid_o, err_repeat_o, dig_o);
    end
  endtask

  // One interval: check previous result, then drive and predict
  task automatic step(bit v, logic [2:0] p);
    int idx;
    @(negedge clk);
    compare();
    smp_vld_i = v;
    pol_i     = p;
    e_vld = 0; e_inv = 0; e_rep = 0; e_tag = "R4";
    if (v) begin
      idx = idx_of(p);
      if (idx < 0) begin
        e_inv = 1; e_tag = "R6";
      end else if (!m_primed) begin
        m_primed = 1; m_prev = idx; e_tag = "R5";
      end else if (idx == m_prev) begin
        e_rep = 1; e_tag = "R7";
      end else begin
        e_vld = 1; e_dig = (idx - m_prev + 6) % 6 - 1; e_tag = "R3";
        m_prev = idx;
      end
    end
  endtask

  task automatic send_digit(int d);
    tx_state = (tx_state + d + 1) % 6;
    step(1, pol_of(tx_state));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_vld_i = 0; pol_i = 3'b000;
    m_primed = 0; m_prev = 0;
    e_vld = 0; e_inv = 0; e_rep = 0; e_dig = 0; e_tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: first cycle after release
    step(0, 3'b000);
    // R4: patterns without strobe are ignored
    step(0, 3'b011); step(0, 3'b111); step(0, 3'b110);
    // R5: first legal sample only primes
    tx_state = 2;
    step(1, pol_of(tx_state));
    // R3/R2: every digit from several states
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 5; d++) send_digit(d);
    // R7: repeated state
    step(1, pol_of(tx_state));
    step(1, pol_of(tx_state));
    send_digit(3);
    // R6: illegal patterns leave state untouched
    step(1, 3'b000);
    send_digit(1);
    step(1, 3'b111);
    step(1, 3'b000);
    send_digit(4);
    // R4: gaps between samples
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 3) == 0) step(0, 3'($urandom));
      else send_digit(int'($urandom % 5));
    end
    // Long back-to-back stream with occasional faults
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 10)
        0: step(1, pol_of(tx_state));
        1: step(1, (($urandom % 2) == 0) ? 3'b000 : 3'b111);
        default: send_digit(int'($urandom % 5));
      endcase
    end
    // R5/R6: mid-run reset, illegal first, then priming
    do_reset();
    step(1, 3'b111);
    tx_state = 5;
    step(1, pol_of(tx_state));
    step(1, pol_of(tx_state));
    send_digit(0);
    send_digit(4);
    step(0, 3'b000);
    step(0, 3'b000);
    done = 1;
    summary();
    $finish;
  end
endmodule